// File: doc/BRIEF.md
# UART Interrupt Source Generator

This block turns the status of a UART into a single interrupt request for the CPU. It watches ten sources: three transmitter and receive-FIFO status levels, the active flags of four DMA buffers (transmit A/B, receive A/B), and three per-character receive error pulses. Each detected event sets a sticky flag bit. Software clears a flag by writing a one to its bit position. The interrupt line is raised when any flag is set and its enable bit is also set.

The three status sources can be configured for edge triggering or level triggering. In edge mode a flag sets on a rising transition of the status. In level mode the flag sets on every clock while the status is high. A DMA buffer reports completion when its active flag goes from high to low. The error inputs are one-cycle pulses, and each pulse sets its flag directly.

The combined interrupt is registered, so it is free of glitches. It follows the flag and enable state with one clock of latency. Prioritising this interrupt against others is done in the chip's interrupt controller, outside this block.

Top module: `uart_irq_gen`

## Requirements
- R1: During and after a synchronous active-low reset, all ten flag bits and the interrupt line read 0.
- R2: With `trig_level` = 0, status sources set their flag only on a 0-to-1 transition of the input. The sources are transmit-idle (bit 0), transmit-free (bit 1) and receive-available (bit 2). A flag that has been cleared stays 0 while its input remains high.
- R3: With `trig_level` = 1, a status source's flag is set on every clock edge at which its input is high. A clear written while the input is still high therefore leaves the flag reading 1.
- R4: A DMA completion flag sets on the clock edge after its active input falls from 1 to 0. The flags are transmit A (bit 3), transmit B (bit 4), receive A (bit 5) and receive B (bit 6). The input rising from 0 to 1 sets no flag.
- R5: A one-cycle pulse on an error input sets its flag. The inputs are parity (bit 7), frame (bit 8) and overrun (bit 9).
- R6: A flag stays set until a write strobe carries a 1 in its bit position. Bits written as 0 are left unchanged.
- R7: When a clear of a flag and a new event for that same flag occur in the same cycle, the flag stays set.
- R8: `irq` is a register that takes the OR over all bits of (flags AND enable), one clock after the flags change. A set flag whose enable bit is 0 does not raise `irq`, and setting that enable bit later raises `irq` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_level | input | 1 | 1 = level triggering, 0 = rising-edge triggering for the status sources |
| st_tx_idle | input | 1 | Transmit FIFO empty and shifter idle |
| st_tx_free | input | 1 | Transmit FIFO has room |
| st_rx_avail | input | 1 | Receive FIFO holds data |
| dma_tx_busy | input | 2 | Transmit DMA buffer active flags, bit 0 = A, bit 1 = B |
| dma_rx_busy | input | 2 | Receive DMA buffer active flags, bit 0 = A, bit 1 = B |
| err_parity | input | 1 | Parity error pulse |
| err_frame | input | 1 | Frame error pulse |
| err_overrun | input | 1 | Receive overrun pulse |
| irq_enable | input | 10 | Per-source enable mask |
| clr_we | input | 1 | Write strobe for clear |
| clr_data | input | 10 | Write-one-to-clear data |
| flags | output | 10 | Sticky per-source flags |
| irq | output | 1 | Registered combined interrupt |

## Verification
The bench holds a status input high after clearing its flag in edge mode. A design that treats the level as an event would set the flag again. It repeats the same sequence in level mode, where a design that forgets to re-arm would leave the flag cleared. It raises a DMA active flag and then drops it, which catches a detector that fires on the wrong polarity. It also fires an event in the same cycle as its own clear; a design that gives priority to the clear loses that event. Masked flags, partial clears and the one-clock latency of `irq` are checked cycle by cycle. These checks catch a combinational output and an enable that is ignored.

// File: rtl/uirq_pkg.sv
// Package: shared source indices and counts for the UART interrupt generator.
// Assumes: source bit order below is the order seen by software in the flags word.
package uirq_pkg;
    localparam int NUM_STATUS = 3;
    localparam int NUM_DMA    = 4;
    localparam int NUM_ERR    = 3;
    localparam int NUM_SRC    = NUM_STATUS + NUM_DMA + NUM_ERR;

    localparam int SRC_TX_IDLE  = 0;
    localparam int SRC_TX_FREE  = 1;
    localparam int SRC_RX_AVAIL = 2;
    localparam int SRC_DMA_BASE = NUM_STATUS;
    localparam int SRC_ERR_BASE = NUM_STATUS + NUM_DMA;
endpackage

// File: rtl/uirq_event_detect.sv
// Module: turns status levels and DMA active flags into one-cycle (or level) events.
// Status inputs: rising edge or level, chosen by trig_level. DMA inputs: falling edge.
// Assumes: all inputs are synchronous to clk. History registers reset to 0.
module uirq_event_detect #(
    parameter int N_STATUS = 3,
    parameter int N_DMA    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig_level,
    input  logic [N_STATUS-1:0] status,
    input  logic [N_DMA-1:0]    dma_busy,
    output logic [N_STATUS-1:0] ev_status,
    output logic [N_DMA-1:0]    ev_dma
);
    logic [N_STATUS-1:0] status_prev_q;
    logic [N_DMA-1:0]    busy_prev_q;

    // Keep last-cycle copies of every watched input for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_prev_q <= '0;
            busy_prev_q   <= '0;
        end else begin
            status_prev_q <= status;
            busy_prev_q   <= dma_busy;
        end
    end

    for (genvar s = 0; s < N_STATUS; s++) begin : g_status
        // Select level or rising-edge event for one status source.
        always_comb begin
            if (trig_level) ev_status[s] = status[s];
            else            ev_status[s] = status[s] & ~status_prev_q[s];
        end

        // R2: in edge mode an event never lasts two consecutive cycles.
        p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig_level && ev_status[s]) |=> !(ev_status[s] && !trig_level));
    end

    for (genvar d = 0; d < N_DMA; d++) begin : g_dma
        // Completion event when a buffer's active flag drops.
        always_comb ev_dma[d] = busy_prev_q[d] & ~dma_busy[d];

        // R4: a completion event is never reported while the buffer is active.
        p_dma_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ev_dma[d] |-> !dma_busy[d]);
    end
endmodule

// File: rtl/uirq_flag_bank.sv
// Module: sticky per-source flags with write-one-to-clear.
// A new event in the same cycle as its clear wins, so no event is lost.
// Assumes: events and the clear strobe are synchronous to clk.
module uirq_flag_bank #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] events,
    input  logic         clr_we,
    input  logic [N-1:0] clr_data,
    output logic [N-1:0] flags
);
    logic [N-1:0] flag_q;
    logic [N-1:0] clr_mask;

    // Bits selected for clearing by this cycle's write.
    always_comb clr_mask = clr_we ? clr_data : '0;

    // Hold, clear, or set each flag; setting has priority over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_mask) | events;
    end

    assign flags = flag_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R7: an event always leaves its flag set on the next cycle.
        p_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
            events[i] |=> flag_q[i]);
        // R6: a set flag survives any cycle that does not clear it.
        p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !(clr_we && clr_data[i])) |=> flag_q[i]);
        // R6: a clear with no competing event empties the flag.
        p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_data[i] && !events[i]) |=> !flag_q[i]);
    end
endmodule

// File: rtl/uirq_combiner.sv
// Module: masks the flags with the enables and registers their OR as the interrupt.
// Assumes: one clock of latency from flags/enable to irq is acceptable.
module uirq_combiner #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enable,
    output logic         irq
);
    logic irq_q;

    // Register the reduction so the line cannot glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flags & enable);
    end

    assign irq = irq_q;

    // R8: an enabled pending flag raises irq on the next edge.
    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags & enable)) |=> irq);
    // R8: no enabled pending flag means irq is low on the next edge.
    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flags & enable)) |=> !irq);
endmodule

// File: rtl/uart_irq_gen.sv
// Module: top of the UART interrupt source generator.
// Flag bit order: 0 tx idle, 1 tx free, 2 rx available, 3..6 DMA tx A, tx B,
// rx A, rx B completion, 7 parity, 8 frame, 9 overrun.
// Assumes: all inputs synchronous to clk; error inputs are one-cycle pulses.
module uart_irq_gen
    import uirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_level,
    input  logic               st_tx_idle,
    input  logic               st_tx_free,
    input  logic               st_rx_avail,
    input  logic [1:0]         dma_tx_busy,
    input  logic [1:0]         dma_rx_busy,
    input  logic               err_parity,
    input  logic               err_frame,
    input  logic               err_overrun,
    input  logic [NUM_SRC-1:0] irq_enable,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_data,
    output logic [NUM_SRC-1:0] flags,
    output logic               irq
);
    logic [NUM_STATUS-1:0] status_vec;
    logic [NUM_DMA-1:0]    busy_vec;
    logic [NUM_STATUS-1:0] ev_status;
    logic [NUM_DMA-1:0]    ev_dma;
    logic [NUM_ERR-1:0]    ev_err;
    logic [NUM_SRC-1:0]    events;

    // Gather inputs into vectors in flag-bit order.
    always_comb begin
        status_vec = '0;
        status_vec[SRC_TX_IDLE]  = st_tx_idle;
        status_vec[SRC_TX_FREE]  = st_tx_free;
        status_vec[SRC_RX_AVAIL] = st_rx_avail;
        busy_vec = {dma_rx_busy, dma_tx_busy};
        ev_err   = {err_overrun, err_frame, err_parity};
    end

    uirq_event_detect #(
        .N_STATUS (NUM_STATUS),
        .N_DMA    (NUM_DMA)
    ) i_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_level (trig_level),
        .status     (status_vec),
        .dma_busy   (busy_vec),
        .ev_status  (ev_status),
        .ev_dma     (ev_dma)
    );

    // Concatenate all event sources into the flag word layout.
    always_comb events = {ev_err, ev_dma, ev_status};

    uirq_flag_bank #(.N(NUM_SRC)) i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .events   (events),
        .clr_we   (clr_we),
        .clr_data (clr_data),
        .flags    (flags)
    );

    uirq_combiner #(.N(NUM_SRC)) i_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .flags  (flags),
        .enable (irq_enable),
        .irq    (irq)
    );

    // R1: flags and interrupt are clear in the cycle after reset is applied.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && !irq));
endmodule

// File: tb/test_uart_irq_gen.sv
module test_uart_irq_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_level = 1'b0;
    logic       st_tx_idle = 1'b0, st_tx_free = 1'b0, st_rx_avail = 1'b0;
    logic [1:0] dma_tx_busy = 2'b00, dma_rx_busy = 2'b00;
    logic       err_parity = 1'b0, err_frame = 1'b0, err_overrun = 1'b0;
    logic [9:0] irq_enable = '0;
    logic       clr_we = 1'b0;
    logic [9:0] clr_data = '0;
    logic [9:0] flags;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    uart_irq_gen i_uart_irq_gen (
        .clk(clk), .rst_n(rst_n), .trig_level(trig_level),
        .st_tx_idle(st_tx_idle), .st_tx_free(st_tx_free), .st_rx_avail(st_rx_avail),
        .dma_tx_busy(dma_tx_busy), .dma_rx_busy(dma_rx_busy),
        .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
        .irq_enable(irq_enable), .clr_we(clr_we), .clr_data(clr_data),
        .flags(flags), .irq(irq)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, actual, expected, $time);
        end
    endtask

    task automatic clear(input logic [9:0] bits);
        clr_we = 1'b1; clr_data = bits;
        step();
        clr_we = 1'b0; clr_data = '0;
    endtask

    task automatic t_reset();
        step(); step();
        check("R1 flags in reset", flags, 0);
        check("R1 irq in reset", irq, 0);
        rst_n = 1'b1;
        step();
        check("R1 flags after reset", flags, 0);
    endtask

    task automatic t_edge();
        trig_level = 1'b0;
        st_tx_idle = 1'b1;
        step();
        check("R2 rise sets tx idle", flags, 10'h001);
        clear(10'h001);
        check("R2 cleared while high", flags, 0);
        step(); step();
        check("R2 no reset while high", flags, 0);
        st_tx_idle = 1'b0; st_tx_free = 1'b1;
        step();
        check("R2 rise sets tx free", flags, 10'h002);
        st_tx_free = 1'b0;
        clear(10'h3FF);
    endtask

    task automatic t_level();
        trig_level = 1'b1;
        st_rx_avail = 1'b1;
        step();
        check("R3 level sets rx avail", flags, 10'h004);
        clear(10'h004);
        check("R3 level re-sets after clear", flags, 10'h004);
        st_rx_avail = 1'b0;
        step();
        clear(10'h004);
        check("R3 cleared once low", flags, 0);
        trig_level = 1'b0;
    endtask

    task automatic t_dma();
        dma_tx_busy = 2'b01;
        step();
        check("R4 rising busy ignored", flags, 0);
        dma_tx_busy = 2'b00;
        step();
        check("R4 tx A completion", flags, 10'h008);
        dma_rx_busy = 2'b10;
        step();
        dma_rx_busy = 2'b00;
        step();
        check("R4 rx B completion", flags, 10'h048);
        clear(10'h3FF);
    endtask

    task automatic t_err();
        err_parity = 1'b1; step(); err_parity = 1'b0;
        err_frame = 1'b1;  step(); err_frame = 1'b0;
        err_overrun = 1'b1; step(); err_overrun = 1'b0;
        check("R5 error flags", flags, 10'h380);
        clear(10'h080);
        check("R6 partial clear", flags, 10'h300);
        step(); step(); step();
        check("R6 flags sticky", flags, 10'h300);
        clear(10'h3FF);
        check("R6 clear all", flags, 0);
    endtask

    task automatic t_collide();
        err_frame = 1'b1; step(); err_frame = 1'b0;
        err_frame = 1'b1; clr_we = 1'b1; clr_data = 10'h100;
        step();
        err_frame = 1'b0; clr_we = 1'b0; clr_data = '0;
        check("R7 event beats clear", flags, 10'h100);
        clear(10'h100);
        check("R7 later clear works", flags, 0);
    endtask

    task automatic t_irq();
        irq_enable = 10'h200;
        err_overrun = 1'b1; step(); err_overrun = 1'b0;
        check("R8 irq latency", irq, 0);
        step();
        check("R8 irq raised", irq, 1);
        clear(10'h200);
        check("R8 irq still high one clock", irq, 1);
        step();
        check("R8 irq dropped", irq, 0);
        err_parity = 1'b1; step(); err_parity = 1'b0;
        step(); step();
        check("R8 masked flag set", flags, 10'h080);
        check("R8 masked no irq", irq, 0);
        irq_enable = 10'h280;
        step();
        check("R8 enable raises irq", irq, 1);
        clear(10'h3FF);
        step();
        check("R8 irq low after clear", irq, 0);
    endtask

    initial begin
        t_reset();
        t_edge();
        t_level();
        t_dma();
        t_err();
        t_collide();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule